// File: doc/BRIEF.md
# SDRAM Command Scheduler with Periodic Refresh

This block turns single-beat read and write requests into the command stream of a 16-bit synchronous DRAM. Each request names a bank, a row, a column, write data and a byte mask. The block opens the row, issues one column command and closes the row again straight away, so no row stays open between accesses. All banks are therefore idle whenever the scheduler itself is idle. The burst length is one. The mode register is assumed to be programmed by a separate power-up sequencer.

Timing minima are given as parameters in picoseconds, together with the clock period. The block turns each one into a clock count by dividing and rounding up. One down-counter per constraint gates the next command. A free-running timer asks for an auto refresh at a fixed interval. A refresh that is owed is served before the next request, but only after the access in flight has closed its row. Read data comes back from the device a programmable CAS latency after the READ command and is passed to the requester with a valid strobe.

Top module: `sdr_cmd_sched`

## Requirements
- R1: The pins (sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n) carry only these codes: idle 0111, open row 0011, read 0101, write 0100, close row 0010, auto refresh 0001, burst stop 0110. Chip select is held low.
- R2: A READ or WRITE follows its open-row command after exactly ceil(tRCD/clock) cycles. At a 7.5 ns clock with 20 ns this is 3 cycles.
- R3: Every access is followed by a single-bank close-row command to the same bank, with sd_addr[10] low. It comes no earlier than ceil(tRAS/clock) cycles after the open-row command (6 at 45 ns) and no earlier than 2 cycles after a WRITE.
- R4: An open-row command comes at least ceil(tRP/clock) cycles after the last close-row command (3 at 20 ns). It also comes at least ceil(tRC/clock) cycles after the last open-row or refresh command (9 at 65 ns).
- R5: The open-row command puts the request row on sd_addr and the bank on sd_ba, with bank codes 0 to 3. READ and WRITE put the column on sd_addr[7:0] and the bank on sd_ba, with sd_addr[10] low so that auto precharge is off.
- R6: On the WRITE cycle, and only then, sd_dq_oe is high, sd_dq_out carries the request data and sd_dqm carries the request mask. A mask bit of 1 blocks its byte: bit 0 covers bits 7:0 and bit 1 covers bits 15:8.
- R7: rd_valid is high exactly CAS_LAT cycles after the cycle in which READ is on the pins. rd_data is then the value on sd_dq_in. Results return in request order.
- R8: Auto refresh is issued only while no row is open and at least ceil(tRP/clock) cycles after the last close-row command. It recurs every floor(REFI_PS/CLK_PS) cycles, within the length of one access.
- R9: An owed refresh is served before any waiting request. A continuous request stream therefore cannot delay a refresh by more than one access.
- R10: During reset the pins show the idle code, sd_dq_oe and rd_valid are low, and sd_dqm is 0. After reset req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the device |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank index |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| req_wdata | input | DQ_W | Write data |
| req_mask | input | DQ_W/8 | Byte mask for the write, 1 blocks the byte |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DQ_W | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_dqm | output | DQ_W/8 | Byte mask pins |
| sd_dq_out | output | DQ_W | Data to the device |
| sd_dq_oe | output | 1 | Data driver enable |
| sd_dq_in | input | DQ_W | Data from the device |

## Verification
The assertions check on every cycle that each pin code is legal and that every cycle-count minimum between commands holds. They also check that no column command or refresh appears with the wrong row state, that the data driver is on only during WRITE, and that the read strobe lines up with the CAS latency. Other behaviour can only be shown by the bench's scenarios. These are: the exact gaps, with the rounding from picoseconds; correct masked data after a read-back through a device model; and refresh priority under a continuous request stream, where a wrong priority starves the refresh.

// File: rtl/sdr_sched_pkg.sv
// Shared constants, types and helpers for the SDRAM command scheduler.
// Assumes a 4-bit command code ordered {cs_n, ras_n, cas_n, we_n}.
package sdr_sched_pkg;

    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_ACT = 4'b0011;
    localparam logic [3:0] CMD_RD  = 4'b0101;
    localparam logic [3:0] CMD_WR  = 4'b0100;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_BST = 4'b0110;

    // Index of each gap timer in the timer bank
    localparam int TI_RCD = 0;
    localparam int TI_RP  = 1;
    localparam int TI_RAS = 2;
    localparam int TI_RC  = 3;
    localparam int TI_RRD = 4;
    localparam int TI_RDL = 5;
    localparam int TI_NUM = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_CLOSE = 2'd2
    } sched_st_e;

    // Round a picosecond minimum up to whole clocks, never below one
    function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
// Down-counter enforcing one minimum command spacing.
// Loaded with (gap - 1) on the cycle the governing command is registered;
// 'expired' is high once the gap has elapsed. Assumes load_val < 2**W.
module sdr_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Reload on a new command, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sdr_refresh_tick.sv
// Periodic refresh request generator.
// Raises 'pending' every INTERVAL cycles; 'ack' clears it. A new tick
// arriving on the same cycle as an ack keeps it set. Assumes INTERVAL >= 2.
module sdr_refresh_tick #(
    parameter int INTERVAL = 2080
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int W = $clog2(INTERVAL + 1);

    logic [W-1:0] cnt;
    logic         tick;

    assign tick = (cnt == '0);

    // Free-running interval counter, reloads after reaching zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= W'(INTERVAL - 1);
        end else if (tick) begin
            cnt <= W'(INTERVAL - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Pending flag: set by tick, cleared by the scheduler's acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (tick) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/sdr_rd_align.sv
// Read-return alignment shift register.
// 'issue' is high in the cycle a READ sits on the pins; 'valid' goes high
// LAT cycles later, the cycle in which the device drives the data.
module sdr_rd_align #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic valid
);
    logic [LAT-1:0] pipe;

    generate
        if (LAT == 1) begin : g_one
            // Single stage for a latency of one
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= issue;
            end
        end else begin : g_many
            // Shift the read marker one stage per clock
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[LAT-2:0], issue};
            end
        end
    endgenerate

    assign valid = pipe[LAT-1];

endmodule

// File: rtl/sdr_cmd_sched.sv
// SDRAM command scheduler, closed-page policy, burst length one.
// Accepts one request at a time: ACTIVE, then READ/WRITE once tRCD has
// elapsed, then a single-bank PRECHARGE once tRAS (and tRDL after a write)
// are met. Refresh is served from idle, when every bank is precharged.
// Assumes the mode register was set by a power-up block (BL=1, CAS_LAT),
// COL_W <= AP_BIT < ROW_W, and all timing minima fit the counter width.
module sdr_cmd_sched
    import sdr_sched_pkg::*;
#(
    parameter  int CLK_PS    = 7500,
    parameter  int T_RCD_PS  = 20000,
    parameter  int T_RP_PS   = 20000,
    parameter  int T_RAS_PS  = 45000,
    parameter  int T_RC_PS   = 65000,
    parameter  int T_RRD_PS  = 15000,
    parameter  int T_RDL_CYC = 2,
    parameter  int REFI_PS   = 15600000,
    parameter  int CAS_LAT   = 3,
    parameter  int BANK_W    = 2,
    parameter  int ROW_W     = 12,
    parameter  int COL_W     = 8,
    parameter  int DQ_W      = 16,
    localparam int MASK_W    = DQ_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [MASK_W-1:0] req_mask,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [MASK_W-1:0] sd_dqm,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);
    localparam int AP_BIT  = 10;
    localparam int RCD_CYC = ps_to_cyc(T_RCD_PS, CLK_PS);
    localparam int RP_CYC  = ps_to_cyc(T_RP_PS,  CLK_PS);
    localparam int RAS_CYC = ps_to_cyc(T_RAS_PS, CLK_PS);
    localparam int RC_CYC  = ps_to_cyc(T_RC_PS,  CLK_PS);
    localparam int RRD_CYC = ps_to_cyc(T_RRD_PS, CLK_PS);
    localparam int RDL_CYC = (T_RDL_CYC < 1) ? 1 : T_RDL_CYC;
    localparam int REFI_CYC = imax(2, REFI_PS / CLK_PS);
    localparam int MAX_CYC = imax(imax(imax(RCD_CYC, RP_CYC), imax(RAS_CYC, RC_CYC)),
                                  imax(RRD_CYC, RDL_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int GAP [TI_NUM] = '{RCD_CYC - 1, RP_CYC - 1, RAS_CYC - 1,
                                    RC_CYC - 1, RRD_CYC - 1, RDL_CYC - 1};

    sched_st_e         state;
    logic              lat_we;
    logic [BANK_W-1:0] lat_bank;
    logic [COL_W-1:0]  lat_col;
    logic [DQ_W-1:0]   lat_data;
    logic [MASK_W-1:0] lat_mask;

    logic [3:0]        cmd_q;
    logic [TI_NUM-1:0] t_load;
    logic [TI_NUM-1:0] t_done;
    logic              ref_pend;
    logic              can_open;
    logic              do_act;
    logic              do_rw;
    logic              do_pre;
    logic              do_ref;

    // One gap timer per timing constraint
    generate
        for (genvar g = 0; g < TI_NUM; g++) begin : g_gap
            sdr_gap_timer #(.W(CNT_W)) u_gap (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (t_load[g]),
                .load_val (CNT_W'(GAP[g])),
                .expired  (t_done[g])
            );
        end
    endgenerate

    sdr_refresh_tick #(.INTERVAL(REFI_CYC)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (do_ref),
        .pending (ref_pend)
    );

    sdr_rd_align #(.LAT(CAS_LAT)) u_rd_align (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (cmd_q == CMD_RD),
        .valid (rd_valid)
    );

    // Issue decisions: refresh wins over a new request while idle
    always_comb begin
        can_open  = t_done[TI_RP] & t_done[TI_RC] & t_done[TI_RRD];
        req_ready = (state == ST_IDLE) & ~ref_pend & can_open;
        do_ref    = (state == ST_IDLE) & ref_pend & t_done[TI_RP] & t_done[TI_RC];
        do_act    = req_valid & req_ready;
        do_rw     = (state == ST_OPEN) & t_done[TI_RCD];
        do_pre    = (state == ST_CLOSE) & t_done[TI_RAS] & t_done[TI_RDL];
    end

    // Which gap timers restart on the command being registered
    always_comb begin
        t_load         = '0;
        t_load[TI_RCD] = do_act;
        t_load[TI_RAS] = do_act;
        t_load[TI_RRD] = do_act;
        t_load[TI_RC]  = do_act | do_ref;
        t_load[TI_RP]  = do_pre;
        t_load[TI_RDL] = do_rw & lat_we;
    end

    // Sequencer state and the request captured at ACTIVE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_we   <= 1'b0;
            lat_bank <= '0;
            lat_col  <= '0;
            lat_data <= '0;
            lat_mask <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (do_act) begin
                    state    <= ST_OPEN;
                    lat_we   <= req_write;
                    lat_bank <= req_bank;
                    lat_col  <= req_col;
                    lat_data <= req_wdata;
                    lat_mask <= req_mask;
                end
                ST_OPEN:  if (do_rw)  state <= ST_CLOSE;
                ST_CLOSE: if (do_pre) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Registered pin drive: NOP unless a command is issued this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= CMD_NOP;
            sd_ba     <= '0;
            sd_addr   <= '0;
            sd_dqm    <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
        end else begin
            cmd_q     <= CMD_NOP;
            sd_ba     <= '0;
            sd_addr   <= '0;
            sd_dqm    <= '0;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
            if (do_ref) begin
                cmd_q <= CMD_REF;
            end else if (do_act) begin
                cmd_q   <= CMD_ACT;
                sd_ba   <= req_bank;
                sd_addr <= req_row;
            end else if (do_rw) begin
                cmd_q   <= lat_we ? CMD_WR : CMD_RD;
                sd_ba   <= lat_bank;
                sd_addr <= {{(ROW_W - COL_W){1'b0}}, lat_col};
                if (lat_we) begin
                    sd_dq_out <= lat_data;
                    sd_dqm    <= lat_mask;
                    sd_dq_oe  <= 1'b1;
                end
            end else if (do_pre) begin
                cmd_q   <= CMD_PRE;
                sd_ba   <= lat_bank;
            end
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign rd_data = sd_dq_in;

endmodule

// File: rtl/sdr_cmd_sched_chk.sv
// Protocol checker for sdr_cmd_sched, watching only its pins.
// Keeps saturating cycle counters since each command kind and a row-open
// flag, and checks the spacing rules against cycle counts given as params.
module sdr_cmd_sched_chk
    import sdr_sched_pkg::*;
#(
    parameter int RCD = 3,
    parameter int RP  = 3,
    parameter int RAS = 6,
    parameter int RC  = 9,
    parameter int RDL = 2,
    parameter int CL  = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ap,
    input logic oe,
    input logic rd_valid
);
    localparam logic [31:0] SAT = 32'h0000_FFFF;

    logic [3:0]  cmd;
    logic        is_act, is_rd, is_wr, is_pre, is_ref;
    logic [31:0] since_act, since_pre, since_ref, since_wr;
    logic        row_open;

    assign cmd    = {cs_n, ras_n, cas_n, we_n};
    assign is_act = (cmd == CMD_ACT);
    assign is_rd  = (cmd == CMD_RD);
    assign is_wr  = (cmd == CMD_WR);
    assign is_pre = (cmd == CMD_PRE);
    assign is_ref = (cmd == CMD_REF);

    // Cycles elapsed since each command kind, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= SAT;
            since_pre <= SAT;
            since_ref <= SAT;
            since_wr  <= SAT;
        end else begin
            since_act <= is_act ? 32'd1 : ((since_act < SAT) ? since_act + 1 : since_act);
            since_pre <= is_pre ? 32'd1 : ((since_pre < SAT) ? since_pre + 1 : since_pre);
            since_ref <= is_ref ? 32'd1 : ((since_ref < SAT) ? since_ref + 1 : since_ref);
            since_wr  <= is_wr  ? 32'd1 : ((since_wr  < SAT) ? since_wr  + 1 : since_wr);
        end
    end

    // Tracks whether a row is open on the device
    always_ff @(posedge clk) begin
        if (!rst_n)      row_open <= 1'b0;
        else if (is_act) row_open <= 1'b1;
        else if (is_pre) row_open <= 1'b0;
    end

    p_cmd_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP) || is_act || is_rd || is_wr || is_pre || is_ref || (cmd == CMD_BST));

    p_rcd_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> (since_act >= 32'(RCD)));

    p_close_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (since_act >= 32'(RAS)) && (since_wr >= 32'(RDL)) && !ap);

    p_close_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> !row_open);

    p_open_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (since_act >= 32'(RC)) && (since_ref >= 32'(RC)) && (since_pre >= 32'(RP)));

    p_col_no_ap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> (row_open && !ap));

    p_oe_only_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> is_wr);

    p_write_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> oe);

    p_rd_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(is_rd, CL));

    p_ref_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (!row_open && since_pre >= 32'(RP)));

endmodule

bind sdr_cmd_sched sdr_cmd_sched_chk #(
    .RCD (RCD_CYC),
    .RP  (RP_CYC),
    .RAS (RAS_CYC),
    .RC  (RC_CYC),
    .RDL (RDL_CYC),
    .CL  (CAS_LAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (sd_cs_n),
    .ras_n    (sd_ras_n),
    .cas_n    (sd_cas_n),
    .we_n     (sd_we_n),
    .ap       (sd_addr[AP_BIT]),
    .oe       (sd_dq_oe),
    .rd_valid (rd_valid)
);

// File: tb/sdr_cmd_sched_tb_top.sv
// Scoreboard bench: a driver task queues expected operations and read
// results; a pin monitor and a device model check the command stream.
module sdr_cmd_sched_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 10;
    localparam int CL         = 3;
    localparam int P_CLK_PS   = 7500;
    localparam int P_REFI_PS  = 2000000;
    // Expected cycle counts worked out from the requirements at 7.5 ns
    localparam int E_RCD  = 3;
    localparam int E_RP   = 3;
    localparam int E_RAS  = 6;
    localparam int E_RC   = 9;
    localparam int E_RDL  = 2;
    localparam int E_REFI = 266;
    localparam int E_TOL  = 12;

    localparam logic [3:0] B_NOP = 4'b0111, B_ACT = 4'b0011, B_RD = 4'b0101,
                           B_WR = 4'b0100, B_PRE = 4'b0010, B_REF = 4'b0001;

    typedef struct packed {
        logic        we;
        logic [1:0]  ba;
        logic [11:0] row;
        logic [7:0]  col;
        logic [15:0] data;
        logic [1:0]  mask;
    } op_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [11:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba, sd_dqm;
    logic [11:0] sd_addr;
    logic [15:0] sd_dq_out, sd_dq_in;

    int n_chk = 0, n_err = 0, cyc = 0, rel_cyc = 0;
    bit finished = 1'b0;

    sdr_cmd_sched #(.CLK_PS(P_CLK_PS), .REFI_PS(P_REFI_PS), .CAS_LAT(CL)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_valid(rd_valid), .rd_data(rd_data), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic [1:0] m);
        logic [15:0] r;
        r = old;
        if (!m[0]) r[7:0]  = d[7:0];
        if (!m[1]) r[15:8] = d[15:8];
        return r;
    endfunction

    // ---------------- device model ----------------
    logic [15:0] mem [bit [23:0]];
    logic [11:0] open_row [4];
    logic [CL-1:0] mpipe = '0;
    logic [15:0]   mdat [CL];

    always @(posedge clk) begin
        logic [3:0]  c;
        logic [23:0] k;
        logic [15:0] old;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        k = {sd_ba, open_row[sd_ba], sd_addr[7:0]};
        if (c == B_ACT) open_row[sd_ba] <= sd_addr;
        if (c == B_WR) begin
            old = mem.exists(k) ? mem[k] : 16'h0000;
            mem[k] = merge(old, sd_dq_out, sd_dqm);
        end
        mpipe <= {mpipe[CL-2:0], (c == B_RD)};
        mdat[0] <= (c == B_RD) ? (mem.exists(k) ? mem[k] : 16'h0000) : 16'hDEAD;
        for (int i = 1; i < CL; i++) mdat[i] <= mdat[i-1];
    end
    assign sd_dq_in = mpipe[CL-1] ? mdat[CL-1] : 16'hBEEF;

    // ---------------- scoreboard ----------------
    op_t         opq[$];
    logic [15:0] rdq[$];
    int          rdcyc[$];
    logic [15:0] shadow [bit [23:0]];

    task automatic do_req(input bit we, input logic [1:0] ba, input logic [11:0] row,
                          input logic [7:0] col, input logic [15:0] d, input logic [1:0] m);
        op_t o;
        logic [23:0] k;
        @(negedge clk);
        req_valid = 1'b1; req_write = we; req_bank = ba; req_row = row;
        req_col = col; req_wdata = d; req_mask = m;
        while (!req_ready) @(negedge clk);
        o = '{we: we, ba: ba, row: row, col: col, data: d, mask: m};
        opq.push_back(o);
        k = {ba, row, col};
        if (we) shadow[k] = merge(shadow.exists(k) ? shadow[k] : 16'h0000, d, m);
        else    rdq.push_back(shadow.exists(k) ? shadow[k] : 16'h0000);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // ---------------- pin monitor ----------------
    int  last_act = -1000, last_pre = -1000, last_ref = -1000, last_wr = -1000;
    int  n_ref = 0;
    bit  row_is_open = 1'b0, last_was_wr = 1'b0;
    logic [1:0] act_ba = '0;

    always @(negedge clk) begin
        logic [3:0] c;
        op_t o;
        int rc;
        logic [15:0] ev;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (rst_n && !finished) begin
            chk(c inside {B_NOP, B_ACT, B_RD, B_WR, B_PRE, B_REF}, "R1", "pin code", c, B_NOP);
            if (c == B_ACT) begin
                chk(cyc - last_pre >= E_RP, "R4", "PRE->ACT gap", cyc - last_pre, E_RP);
                chk(cyc - last_act >= E_RC, "R4", "ACT->ACT gap", cyc - last_act, E_RC);
                chk(cyc - last_ref >= E_RC, "R4", "REF->ACT gap", cyc - last_ref, E_RC);
                chk(!row_is_open, "R3", "previous row closed", row_is_open, 0);
                chk(opq.size() > 0, "R5", "ACT matches a request", opq.size(), 1);
                if (opq.size() > 0) begin
                    chk(sd_addr == opq[0].row, "R5", "ACT row", sd_addr, opq[0].row);
                    chk(sd_ba == opq[0].ba, "R5", "ACT bank", sd_ba, opq[0].ba);
                end
                last_act = cyc; row_is_open = 1'b1; act_ba = sd_ba;
            end
            if (c == B_RD || c == B_WR) begin
                chk(cyc - last_act == E_RCD, "R2", "ACT->column gap", cyc - last_act, E_RCD);
                if (opq.size() > 0) begin
                    o = opq.pop_front();
                    chk(sd_addr[10] == 1'b0, "R5", "A10 on column cmd", sd_addr[10], 0);
                    chk(sd_addr[7:0] == o.col, "R5", "column", sd_addr[7:0], o.col);
                    chk(sd_ba == o.ba, "R5", "column bank", sd_ba, o.ba);
                    chk((c == B_WR) == o.we, "R5", "read/write kind", c, o.we ? B_WR : B_RD);
                    if (c == B_WR) begin
                        chk(sd_dq_oe == 1'b1, "R6", "oe on write", sd_dq_oe, 1);
                        chk(sd_dq_out == o.data, "R6", "write data", sd_dq_out, o.data);
                        chk(sd_dqm == o.mask, "R6", "write mask", sd_dqm, o.mask);
                    end
                end
                if (c == B_RD) rdcyc.push_back(cyc);
                last_was_wr = (c == B_WR);
                if (c == B_WR) last_wr = cyc;
            end
            if (c != B_WR && sd_dq_oe)
                chk(1'b0, "R6", "oe outside write", sd_dq_oe, 0);
            if (c == B_PRE) begin
                chk(cyc - last_act >= E_RAS, "R3", "ACT->PRE gap", cyc - last_act, E_RAS);
                if (last_was_wr)
                    chk(cyc - last_wr >= E_RDL, "R3", "WR->PRE gap", cyc - last_wr, E_RDL);
                chk(sd_addr[10] == 1'b0, "R3", "single-bank close", sd_addr[10], 0);
                chk(sd_ba == act_ba, "R3", "close bank", sd_ba, act_ba);
                last_pre = cyc; row_is_open = 1'b0;
            end
            if (c == B_REF) begin
                chk(!row_is_open, "R8", "refresh with rows closed", row_is_open, 0);
                chk(cyc - last_pre >= E_RP, "R8", "PRE->REF gap", cyc - last_pre, E_RP);
                if (n_ref == 0)
                    chk(cyc - rel_cyc <= E_REFI + E_TOL, "R9", "first refresh delay",
                        cyc - rel_cyc, E_REFI);
                else
                    chk((cyc - last_ref <= E_REFI + E_TOL) && (cyc - last_ref >= E_REFI - E_TOL),
                        "R9", "refresh interval", cyc - last_ref, E_REFI);
                last_ref = cyc; n_ref++;
            end
            if (rd_valid) begin
                chk(rdcyc.size() > 0 && rdq.size() > 0, "R7", "read strobe expected",
                    rdcyc.size(), 1);
                if (rdcyc.size() > 0 && rdq.size() > 0) begin
                    rc = rdcyc.pop_front();
                    ev = rdq.pop_front();
                    chk(cyc - rc == CL, "R7", "read latency", cyc - rc, CL);
                    chk(rd_data == ev, "R7", "read data", rd_data, ev);
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == B_NOP, "R10", "reset pins NOP",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, B_NOP);
        chk(sd_dq_oe == 1'b0, "R10", "reset oe", sd_dq_oe, 0);
        chk(rd_valid == 1'b0, "R10", "reset rd_valid", rd_valid, 0);
        chk(sd_dqm == 2'b00, "R10", "reset dqm", sd_dqm, 0);
        rst_n = 1'b1;
        rel_cyc = cyc;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);

        // Basic write/read and both byte masks (R6, R7)
        do_req(1, 2'd0, 12'd5, 8'd3, 16'hA5A5, 2'b00);
        do_req(0, 2'd0, 12'd5, 8'd3, 16'h0000, 2'b00);
        do_req(1, 2'd0, 12'd5, 8'd3, 16'h1234, 2'b01);
        do_req(0, 2'd0, 12'd5, 8'd3, 16'h0000, 2'b00);
        do_req(1, 2'd0, 12'd5, 8'd3, 16'hFF66, 2'b10);
        do_req(0, 2'd0, 12'd5, 8'd3, 16'h0000, 2'b00);
        do_req(1, 2'd0, 12'd5, 8'd3, 16'h7777, 2'b11);
        do_req(0, 2'd0, 12'd5, 8'd3, 16'h0000, 2'b00);
        // Every bank, extreme row and column (R5)
        do_req(1, 2'd1, 12'd4095, 8'd255, 16'h0F0F, 2'b00);
        do_req(1, 2'd2, 12'd0,    8'd0,   16'hC001, 2'b00);
        do_req(1, 2'd3, 12'd2048, 8'd128, 16'h8421, 2'b00);
        do_req(0, 2'd3, 12'd2048, 8'd128, 16'h0000, 2'b00);
        do_req(0, 2'd1, 12'd4095, 8'd255, 16'h0000, 2'b00);
        do_req(0, 2'd2, 12'd0,    8'd0,   16'h0000, 2'b00);
        do_req(0, 2'd2, 12'd1,    8'd9,   16'h0000, 2'b00);
        // Continuous stream across several refresh intervals (R8, R9)
        for (int i = 0; i < 80; i++) begin
            do_req(1, 2'(i % 4), 12'((i * 37) % 4096), 8'((i * 13) % 256),
                   16'((i * 16'h1357) ^ 16'hC3A5), (i % 3 == 0) ? 2'b10 : 2'b00);
            do_req(0, 2'(i % 4), 12'((i * 37) % 4096), 8'((i * 13) % 256),
                   16'h0000, 2'b00);
        end
        repeat (CL + 12) @(negedge clk);
        chk(rdq.size() == 0, "R7", "all reads returned", rdq.size(), 0);
        // Idle: refresh keeps running with no traffic (R8)
        repeat (E_REFI + 40) @(negedge clk);
        chk(n_ref >= (cyc - rel_cyc) / E_REFI - 1, "R8", "refresh count",
            n_ref, (cyc - rel_cyc) / E_REFI - 1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule